// File: doc/BRIEF.md
# Glitch-Free Programmable Clock Output Generator

This block derives a programmable output clock from a 48 MHz reference. A 4-bit division field N sets the output period to N+1 reference cycles, so the output runs anywhere from 3 MHz to 48 MHz. After a hardware reset the active division is N = 3, which gives 12 MHz.

The divider accepts a new field value only when a full output period ends. A change made in the middle of a period therefore never cuts a phase short.

The block also sequences the output during a suspend request. While the request is held, a delay counter runs in reference cycles. When it expires, three things can happen, chosen by two configuration bits:
- the output switches to a slow fallback clock;
- the output keeps the divided clock;
- the output is parked low.

Separately, an internal-clock-enable flag drops unless the always-run bit is set. The output moves from one source to another only while both sources are low. Withdrawing the request, or pulsing the bus-reset input, cancels the pending or active suspend. A bus reset does not disturb the active divisor.

Top module: `clkout_gen`

## Requirements
- R1: For N from 1 to 15 the output period is N+1 reference cycles. The high phase lasts ceil((N+1)/2) cycles and the low phase lasts floor((N+1)/2) cycles, so an odd division ratio is high one cycle longer than low.
- R2: During hardware reset the output is high and the enable flag is high. The active divisor is 3 whatever the field holds. After release, the first period is 2 cycles high and then 2 cycles low.
- R3: A new field value is taken only at the end of a complete output period. A period already under way finishes with its old high and low lengths, and the next period uses the new value.
- R4: With N = 0 the output follows the reference clock: high while the reference is high and low while it is low.
- R5: With the fallback allowed (no-fallback bit 0), once suspend is established the output follows the fallback clock. The fallback level toggles on every fallback tick. The source changes only while the outgoing source is low.
- R6: With the always-run bit 0 and go-suspend held, the enable flag stays high through the first SUSP_DELAY-1 rising edges. It goes low at the SUSP_DELAY-th edge.
- R7: With the always-run bit 1 the enable flag never drops. If the no-fallback bit is also 1, the divided clock keeps running through suspend.
- R8: With the no-fallback bit 1 and the always-run bit 0, an established suspend parks the output low.
- R9: With the no-fallback bit 1 the fallback clock is never selected as the output source.
- R10: When go-suspend is sampled low, the enable flag is high after that edge. The output returns to the divided clock, starting with a complete period.
- R11: A bus-reset pulse restarts the suspend delay, so a further SUSP_DELAY edges are needed before the enable flag drops. It leaves the active divisor as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 48 MHz reference clock |
| rst_ni | input | 1 | Hardware reset, active low, asynchronous |
| bus_rst_i | input | 1 | Bus reset; cancels suspend and keeps the divisor |
| div_i | input | DIV_W | Division field N |
| nolazy_i | input | 1 | 1 = never drive the fallback clock on the output |
| clkrun_i | input | 1 | 1 = internal clocks keep running in suspend |
| go_susp_i | input | 1 | Suspend request, held while suspend is wanted |
| slow_tick_i | input | 1 | One-cycle tick; each tick toggles the fallback level |
| clk_o | output | 1 | Generated output clock |
| clk_en_o | output | 1 | Internal-clock-enable flag |

## Verification
The divided output is registered, so a phase boundary appears one reference edge after the counter reaches its limit. The bench therefore samples one nanosecond after each rising edge and counts high and low phases in whole edges. A divisor change is measured over the period in progress and over the one after it, so both the old lengths and the new lengths are seen.

The enable flag is decoded from the delay timer's flag, so it falls in exactly the SUSP_DELAY-th sample after go-suspend is first seen. It rises in the first sample after a cancel. The bench checks it at the sample before and at the sample after each of these boundaries. For N = 0, samples are also taken just after falling edges to observe the low half of the reference clock.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

   // Output source selector
   typedef enum logic [1:0] {
      SRC_DIV  = 2'd0,
      SRC_SLOW = 2'd1,
      SRC_OFF  = 2'd2
   } clk_src_e;

endpackage

// File: rtl/clkout_div_core.sv
// Programmable divider: period n+1 reference cycles, divisor latched only at
// period end, parks low on request at a period end, bypass for n == 0.
module clkout_div_core #(
   parameter int unsigned DIV_W   = 4,
   parameter int unsigned RST_DIV = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] div_i,
   input  logic             run_i,
   output logic             lvl_o,
   output logic             parked_o,
   output logic             wrap_o,
   output logic [DIV_W-1:0] n_o
);

   localparam logic [DIV_W-1:0] RST_N = DIV_W'(RST_DIV);

   logic [DIV_W-1:0] n_q, n_d;
   logic [DIV_W-1:0] cnt_q, cnt_d;
   logic             lvl_q, lvl_d;
   logic             act_q, act_d;
   logic             byp_q;
   logic             wrap;

   // High phase length: ceil((n+1)/2)
   function automatic logic [DIV_W:0] hi_len(input logic [DIV_W-1:0] n);
      logic [DIV_W:0] s;
      s = {1'b0, n} + (DIV_W+1)'(2);
      return s >> 1;
   endfunction

   assign wrap = (cnt_q == n_q);

   always_comb begin
      n_d   = n_q;
      cnt_d = cnt_q;
      lvl_d = lvl_q;
      act_d = act_q;
      if (!act_q || wrap) begin
         if (run_i) begin
            n_d   = div_i;
            cnt_d = '0;
            lvl_d = 1'b1;
            act_d = 1'b1;
         end else begin
            lvl_d = 1'b0;
            act_d = 1'b0;
         end
      end else begin
         cnt_d = cnt_q + 1'b1;
         lvl_d = ({1'b0, cnt_d} < hi_len(n_q));
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         n_q   <= RST_N;
         cnt_q <= '0;
         lvl_q <= 1'b1;
         act_q <= 1'b1;
      end else begin
         n_q   <= n_d;
         cnt_q <= cnt_d;
         lvl_q <= lvl_d;
         act_q <= act_d;
      end
   end

   // Bypass enable changes only while the reference is low
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byp_q <= 1'b0;
      else         byp_q <= act_q && (n_q == '0);
   end

   assign lvl_o    = byp_q ? clk_i : lvl_q;
   assign parked_o = !act_q;
   assign wrap_o   = wrap;
   assign n_o      = n_q;

endmodule

// File: rtl/clkout_susp_timer.sv
// Counts reference cycles while the suspend request is held.
module clkout_susp_timer #(
   parameter int unsigned SUSP_DELAY = 96000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic go_i,
   input  logic abort_i,
   output logic susp_o
);

   localparam int unsigned CW = $clog2(SUSP_DELAY + 1);
   localparam logic [CW-1:0] LAST = CW'(SUSP_DELAY - 1);

   logic [CW-1:0] cnt_q;
   logic          susp_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         susp_q <= 1'b0;
      end else if (!go_i || abort_i) begin
         cnt_q  <= '0;
         susp_q <= 1'b0;
      end else if (!susp_q) begin
         if (cnt_q == LAST) susp_q <= 1'b1;
         else               cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign susp_o = susp_q;

endmodule

// File: rtl/clkout_src_sel.sv
// Fallback level generator and low-side source switch.
module clkout_src_sel
   import clkout_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     susp_i,
   input  logic     nolazy_i,
   input  logic     clkrun_i,
   input  logic     slow_tick_i,
   input  logic     div_parked_i,
   output clk_src_e sel_o,
   output logic     slow_lvl_o,
   output logic     run_o
);

   clk_src_e sel_q, tgt;
   logic     slow_q;
   logic     can_leave, can_enter;

   always_comb begin
      if (!susp_i)       tgt = SRC_DIV;
      else if (!nolazy_i) tgt = SRC_SLOW;
      else if (clkrun_i) tgt = SRC_DIV;
      else               tgt = SRC_OFF;
   end

   always_comb begin
      unique case (sel_q)
         SRC_DIV:  can_leave = div_parked_i;
         SRC_SLOW: can_leave = !slow_q;
         default:  can_leave = 1'b1;
      endcase
      can_enter = (tgt != SRC_SLOW) || !slow_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q  <= SRC_DIV;
         slow_q <= 1'b0;
      end else begin
         if (slow_tick_i) slow_q <= !slow_q;
         if ((tgt != sel_q) && can_leave && can_enter) sel_q <= tgt;
      end
   end

   assign sel_o      = sel_q;
   assign slow_lvl_o = slow_q;
   assign run_o      = (sel_q == SRC_DIV) && (tgt == SRC_DIV);

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
   import clkout_pkg::*;
#(
   parameter int unsigned DIV_W      = 4,
   parameter int unsigned RST_DIV    = 3,
   parameter int unsigned SUSP_DELAY = 96000
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             bus_rst_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             nolazy_i,
   input  logic             clkrun_i,
   input  logic             go_susp_i,
   input  logic             slow_tick_i,
   output logic             clk_o,
   output logic             clk_en_o
);

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_width
         $error("clkout_gen: DIV_W out of range");
      end
      if (RST_DIV >= (1 << DIV_W)) begin : g_bad_rst
         $error("clkout_gen: RST_DIV does not fit DIV_W");
      end
      if (SUSP_DELAY < 2) begin : g_bad_delay
         $error("clkout_gen: SUSP_DELAY must be at least 2");
      end
   endgenerate

   logic             div_lvl, div_parked, div_wrap, run;
   logic [DIV_W-1:0] div_n;
   logic             susp, slow_lvl;
   clk_src_e         sel;

   clkout_div_core #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .div_i    (div_i),
      .run_i    (run),
      .lvl_o    (div_lvl),
      .parked_o (div_parked),
      .wrap_o   (div_wrap),
      .n_o      (div_n)
   );

   clkout_susp_timer #(.SUSP_DELAY(SUSP_DELAY)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .go_i    (go_susp_i),
      .abort_i (bus_rst_i),
      .susp_o  (susp)
   );

   clkout_src_sel u_sel (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .susp_i       (susp),
      .nolazy_i     (nolazy_i),
      .clkrun_i     (clkrun_i),
      .slow_tick_i  (slow_tick_i),
      .div_parked_i (div_parked),
      .sel_o        (sel),
      .slow_lvl_o   (slow_lvl),
      .run_o        (run)
   );

   always_comb begin
      unique case (sel)
         SRC_DIV:  clk_o = div_lvl;
         SRC_SLOW: clk_o = slow_lvl;
         default:  clk_o = 1'b0;
      endcase
   end

   assign clk_en_o = !(susp && !clkrun_i);

endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk
   import clkout_pkg::*;
#(
   parameter int unsigned DIV_W = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             go_susp_i,
   input logic             clkrun_i,
   input logic             nolazy_i,
   input logic             clk_o,
   input logic             clk_en_o,
   input clk_src_e         sel,
   input logic [DIV_W-1:0] div_n,
   input logic             div_wrap
);

   // R7: always-run keeps the enable flag high
   assert_always_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clkrun_i |-> clk_en_o);

   // R10: request sampled low restores the enable flag
   assert_cancel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !go_susp_i |=> clk_en_o);

   // R6: the flag only falls while the request is held
   assert_en_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(clk_en_o) |-> $past(go_susp_i));

   // R9: fallback is not entered while it is forbidden
   assert_no_fallback_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel != SRC_SLOW && nolazy_i) |=> sel != SRC_SLOW);

   // R3: active divisor changes only at a period end
   assert_div_at_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_n != $past(div_n)) |-> $past(div_wrap));

   // R5: source changes only while the output is low
   assert_switch_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel != $past(sel)) |-> !$past(clk_o));

endmodule

bind clkout_gen clkout_gen_chk #(.DIV_W(DIV_W)) i_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .go_susp_i (go_susp_i),
   .clkrun_i  (clkrun_i),
   .nolazy_i  (nolazy_i),
   .clk_o     (clk_o),
   .clk_en_o  (clk_en_o),
   .sel       (sel),
   .div_n     (div_n),
   .div_wrap  (div_wrap)
);

// File: tb/test_clkout_gen.sv
`timescale 1ns/1ps
module test_clkout_gen;

   localparam int D = 40;

   logic       clk = 1'b0;
   logic       rst_ni = 1'b0;
   logic       bus_rst = 1'b0;
   logic [3:0] div = 4'd7;
   logic       nolazy = 1'b0;
   logic       clkrun = 1'b0;
   logic       go = 1'b0;
   logic       tick = 1'b0;
   logic       clk_o, clk_en_o;

   int nchecks = 0;
   int nerr = 0;
   bit done = 0;

   always #2 clk = ~clk;

   clkout_gen #(.DIV_W(4), .RST_DIV(3), .SUSP_DELAY(D)) i_clkout_gen (
      .clk_i(clk), .rst_ni(rst_ni), .bus_rst_i(bus_rst), .div_i(div),
      .nolazy_i(nolazy), .clkrun_i(clkrun), .go_susp_i(go),
      .slow_tick_i(tick), .clk_o(clk_o), .clk_en_o(clk_en_o)
   );

   // fallback tick every 10 cycles
   initial begin
      int c = 0;
      forever begin
         @(posedge clk); #1;
         c = (c + 1) % 10;
         tick = (c == 9);
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic check(input string req, input int act, input int exp);
      nchecks++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic measure(output int hi, output int lo);
      logic prev;
      int   guard = 0;
      hi = 0; lo = 0;
      step(); prev = clk_o;
      forever begin
         step();
         if (!prev && clk_o) break;
         prev = clk_o;
         if (++guard > 2000) begin hi = -1; return; end
      end
      hi = 1;
      forever begin step(); if (!clk_o) break; hi++; if (hi > 2000) return; end
      lo = 1;
      forever begin step(); if (clk_o) break; lo++; if (lo > 2000) return; end
   endtask

   task automatic test_reset();
      for (int i = 0; i < 3; i++) step();
      check("R2 out in reset", clk_o, 1);
      check("R2 en in reset", clk_en_o, 1);
      rst_ni = 1'b1;
      step(); check("R2 edge1", clk_o, 1);
      step(); check("R2 edge2", clk_o, 0);
      step(); check("R2 edge3", clk_o, 0);
      step(); check("R2 edge4", clk_o, 1);
   endtask

   task automatic test_sweep();
      int hi, lo;
      int ns[5] = '{1, 2, 5, 14, 15};
      foreach (ns[k]) begin
         div = 4'(ns[k]);
         measure(hi, lo);
         measure(hi, lo);
         check($sformatf("R1 high N=%0d", ns[k]), hi, (ns[k] + 2) / 2);
         check($sformatf("R1 low N=%0d", ns[k]), lo, (ns[k] + 1) - (ns[k] + 2) / 2);
      end
   endtask

   task automatic test_change();
      int hi, lo;
      logic prev;
      div = 4'd15;
      measure(hi, lo);
      step(); prev = clk_o;
      forever begin step(); if (!prev && clk_o) break; prev = clk_o; end
      step();
      div = 4'd1;                          // change in mid high phase
      hi = 2;
      forever begin step(); if (!clk_o) break; hi++; if (hi > 100) break; end
      lo = 1;
      forever begin step(); if (clk_o) break; lo++; if (lo > 100) break; end
      check("R3 old high kept", hi, 8);
      check("R3 old low kept", lo, 8);
      measure(hi, lo);
      check("R3 new high", hi, 1);
      check("R3 new low", lo, 1);
   endtask

   task automatic test_bypass();
      int hi, lo;
      div = 4'd0;
      for (int i = 0; i < 40; i++) step();
      for (int i = 0; i < 3; i++) begin
         @(posedge clk); #1; check("R4 ref high", clk_o, 1);
         @(negedge clk); #1; check("R4 ref low", clk_o, 0);
      end
      div = 4'd3;
      measure(hi, lo);
      measure(hi, lo);
      check("R4 leave bypass", hi * 10 + lo, 22);
   endtask

   task automatic test_fallback();
      int hi, lo;
      div = 4'd5; nolazy = 1'b0; clkrun = 1'b0;
      measure(hi, lo);
      go = 1'b1;
      for (int i = 1; i < D; i++) step();
      check("R6 en before delay", clk_en_o, 1);
      step();
      check("R6 en at delay", clk_en_o, 0);
      measure(hi, lo);
      measure(hi, lo);
      check("R5 fallback high", hi, 10);
      check("R5 fallback low", lo, 10);
      go = 1'b0;
      step();
      check("R10 en restored", clk_en_o, 1);
      measure(hi, lo);
      measure(hi, lo);
      check("R10 divided high", hi, 3);
      check("R10 divided low", lo, 3);
   endtask

   task automatic test_keep_running();
      int hi, lo;
      div = 4'd2; nolazy = 1'b1; clkrun = 1'b1;
      go = 1'b1;
      for (int i = 0; i < D + 5; i++) step();
      check("R7 en kept", clk_en_o, 1);
      measure(hi, lo);
      check("R7 high", hi, 2);
      check("R7 low", lo, 1);
      go = 1'b0;
      step();
   endtask

   task automatic test_park();
      int hi, lo, highs = 0;
      div = 4'd4; nolazy = 1'b1; clkrun = 1'b0;
      go = 1'b1;
      for (int i = 0; i < D + 20; i++) step();
      check("R8 en low", clk_en_o, 0);
      for (int i = 0; i < 100; i++) begin step(); if (clk_o) highs++; end
      check("R8 R9 output parked", highs, 0);
      go = 1'b0;
      step();
      check("R10 en after park", clk_en_o, 1);
      measure(hi, lo);
      measure(hi, lo);
      check("R10 after park", hi * 10 + lo, 32);
   endtask

   task automatic test_bus_reset();
      int hi, lo;
      div = 4'd4; nolazy = 1'b0; clkrun = 1'b0;
      measure(hi, lo);
      go = 1'b1;
      for (int i = 0; i < D / 2; i++) step();
      bus_rst = 1'b1; step(); bus_rst = 1'b0;
      for (int i = 1; i < D; i++) step();
      check("R11 delay restarted", clk_en_o, 1);
      step();
      check("R11 en after full delay", clk_en_o, 0);
      go = 1'b0;
      measure(hi, lo);
      measure(hi, lo);
      check("R11 divisor kept", hi * 10 + lo, 32);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      nchecks++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      test_reset();
      begin
         int hi, lo;
         measure(hi, lo);
         check("R2 then field N=7 high", hi, 4);
         check("R2 then field N=7 low", lo, 4);
      end
      test_sweep();
      test_change();
      test_bypass();
      test_fallback();
      test_keep_running();
      test_park();
      test_bus_reset();
      finish_run();
   end

endmodule